// File: doc/BRIEF.md
# Flash Command Lane Replicator and Address Mapper

This block sits between a flash sequencer and a parallel NOR flash data bus made of one or more identical devices placed side by side. For a write it spreads one 8-bit command byte across the bus so that each device receives it on a single lane. For a read it picks one lane, or ORs the status lanes of all devices into one byte. It can also gather a 16-bit or 32-bit query value from two or four successive bus words. It computes every byte address from a base, a sector offset and a word offset scaled by the bus width.

The sequencer hands over one request at a time through a valid/ready pair. The block runs the one to four bus accesses the request needs, one at a time, each held until the bus acknowledges it. It then returns a single-cycle response. The bus width, the chip width, the byte order, a bus-swap option and a mode that treats x16 devices as x8 are configuration inputs. They are sampled when a request is accepted. The controller has three states. ST_IDLE accepts a request. ST_ACCESS drives the current access until it is acknowledged. ST_RESP presents the result. The transitions are: ST_IDLE to ST_ACCESS on a good request, ST_IDLE to ST_RESP on a rejected request, ST_ACCESS to itself on an acknowledged beat that is not the last, ST_ACCESS to ST_RESP on the acknowledge of the last beat, and ST_RESP back to ST_IDLE after one cycle.

Top module: `flash_lane_mapper`

## Requirements
- R1: A request is rejected with `rsp_err`=1 and no bus access when the bus width or chip width (both in bytes) is zero, is not a power of two, exceeds 4 for the bus, or when the chip width exceeds the bus width.
- R2: For op 0 (command) the block makes one write access. Lane k is `bus_wdata[8k+7:8k]`. Lanes at or above the bus width are zero. A lane below the bus width carries the command byte only when its position index ANDed with (chip width − 1) is zero, and carries zero otherwise. The response data is zero.
- R3: The effective order is big-endian when `cfg_big_endian` XOR `cfg_bus_swap` is 1. In little-endian order, lane k has index (bus width − k). In big-endian order, lane k has index k+1.
- R4: The byte address of beat i is base + S + W × bus width. S is `req_sect_off`, or 0 when `req_sector` is 0. W is `req_offset` + i.
- R5: With `cfg_x16_as_x8` set, W becomes 2 × (`req_offset` + i), so each beat is a separate single read at the doubled offset.
- R6: Op 1 makes one read and returns lane 0 in little-endian order, or lane (bus width − 1) in big-endian order, in `rsp_data[7:0]`. The upper bits are zero.
- R7: Op 2 makes one read and returns the OR of n = bus width / chip width lanes in `rsp_data[7:0]`. These are lanes 0 to n−1 in little-endian order, or lanes bus width − 1 down to bus width − n in big-endian order.
- R8: Op 3 makes two reads and op 4 makes four reads. Each beat takes its selected lane as in R6, and beat i fills `rsp_data[8i+7:8i]`, so the first word is the low byte.
- R9: `req_ready` is high only while idle. Only one access is in flight at a time, and its address and data hold until `bus_ack`. Each request produces exactly one single-cycle `rsp_valid`.
- R10: Op codes 5 to 7 are rejected with `rsp_err`=1 and no bus access.
- R11: After reset, `req_ready`=1, `bus_req`=0 and `rsp_valid`=0.
- R12: The configuration inputs are sampled when a request is accepted. Changing them while the request is in progress has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Bank base byte address |
| cfg_bus_bytes | input | CW_W | Bus width in bytes |
| cfg_chip_bytes | input | CW_W | Per-device width in bytes |
| cfg_big_endian | input | 1 | Host byte order is big-endian |
| cfg_bus_swap | input | 1 | Invert the host byte order |
| cfg_x16_as_x8 | input | 1 | Double the word offset, one read per beat |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_op | input | 3 | 0 command, 1 byte query, 2 status, 3 16-bit query, 4 32-bit query |
| req_cmd | input | 8 | Command byte |
| req_sector | input | SECT_W | Sector number |
| req_sect_off | input | ADDR_W | Byte offset of that sector |
| req_offset | input | OFF_W | Word offset within the sector |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_err | output | 1 | Request rejected |
| rsp_data | output | 32 | Assembled read value |
| bus_req | output | 1 | Bus access pending |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 8*MAX_BUS_BYTES | Write data, lane k in bits 8k+7:8k |
| bus_ack | input | 1 | Access completed |
| bus_rdata | input | 8*MAX_BUS_BYTES | Read data, valid with bus_ack |

## Verification
Two things can happen in the same cycle: the acceptance of a request and a change of the configuration inputs. The block must bind the request to the configuration seen at acceptance. In random runs the bench scrambles every configuration input in the cycle right after acceptance, while the bus access is still waiting for a randomly delayed acknowledge. It then judges the lane placement, the addresses and the merged or assembled bytes against the configuration it recorded at acceptance. A second overlap is the acknowledge of a non-final beat together with the address step to the next beat. This is judged by comparing every logged address against the per-beat formula.

// File: rtl/flm_pkg.sv
package flm_pkg;
    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_Q8   = 3'd1,
        OP_STAT = 3'd2,
        OP_Q16  = 3'd3,
        OP_Q32  = 3'd4
    } flm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_RESP
    } flm_state_e;
endpackage

// File: rtl/flm_cfg_check.sv
module flm_cfg_check #(
    parameter int MAX_BUS_BYTES = 4,
    parameter int CW_W = $clog2(MAX_BUS_BYTES) + 1
) (
    input  logic [CW_W-1:0] bus_bytes,
    input  logic [CW_W-1:0] chip_bytes,
    output logic            cfg_ok
);
    localparam logic [CW_W-1:0] ONE  = CW_W'(1);
    localparam logic [CW_W-1:0] MAXV = CW_W'(MAX_BUS_BYTES);

    assign cfg_ok = (bus_bytes != '0) && (chip_bytes != '0)
                 && ((bus_bytes & (bus_bytes - ONE)) == '0)
                 && ((chip_bytes & (chip_bytes - ONE)) == '0)
                 && (chip_bytes <= bus_bytes)
                 && (bus_bytes <= MAXV);
endmodule

// File: rtl/flm_lane_fill.sv
module flm_lane_fill #(
    parameter int MAX_BUS_BYTES = 4,
    parameter int CW_W = $clog2(MAX_BUS_BYTES) + 1,
    localparam int DW = 8 * MAX_BUS_BYTES
) (
    input  logic [7:0]      cmd,
    input  logic [CW_W-1:0] bus_bytes,
    input  logic [CW_W-1:0] chip_bytes,
    input  logic            big,
    output logic [DW-1:0]   wdata
);
    for (genvar k = 0; k < MAX_BUS_BYTES; k++) begin : g_lane
        logic [CW_W-1:0] idx;
        logic [7:0]      lane_b;
        always_comb begin
            idx = big ? CW_W'(k + 1) : (bus_bytes - CW_W'(k));
            if (CW_W'(k) >= bus_bytes)
                lane_b = '0;
            else if ((idx & (chip_bytes - CW_W'(1))) == '0)
                lane_b = cmd;
            else
                lane_b = '0;
        end
        assign wdata[8*k +: 8] = lane_b;
    end
endmodule

// File: rtl/flm_addr_map.sv
module flm_addr_map #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int CW_W   = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] sect_off,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        beat,
    input  logic              x16,
    input  logic [CW_W-1:0]   bus_bytes,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] word, scaled;

    always_comb begin
        word   = ADDR_W'(offset) + ADDR_W'(beat);
        scaled = x16 ? (word << 1) : word;
        addr   = base + sect_off + scaled * ADDR_W'(bus_bytes);
    end
endmodule

// File: rtl/flm_read_merge.sv
module flm_read_merge #(
    parameter int MAX_BUS_BYTES = 4,
    parameter int CW_W = $clog2(MAX_BUS_BYTES) + 1,
    localparam int DW = 8 * MAX_BUS_BYTES
) (
    input  logic [DW-1:0]   rdata,
    input  logic [CW_W-1:0] bus_bytes,
    input  logic [CW_W-1:0] chip_bytes,
    input  logic            big,
    output logic [7:0]      pick,
    output logic [7:0]      merged
);
    int b, c;
    assign b = int'(bus_bytes);
    assign c = int'(chip_bytes);

    always_comb begin
        pick   = '0;
        merged = '0;
        for (int k = 0; k < MAX_BUS_BYTES; k++) begin
            if (!big && k == 0)
                pick = rdata[8*k +: 8];
            if (big && k == b - 1)
                pick = rdata[8*k +: 8];
            if (big ? ((k < b) && ((b - 1 - k) * c < b)) : (k * c < b))
                merged = merged | rdata[8*k +: 8];
        end
    end
endmodule

// File: rtl/flash_lane_mapper.sv
module flash_lane_mapper
    import flm_pkg::*;
#(
    parameter int MAX_BUS_BYTES = 4,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int SECT_W = 8,
    localparam int CW_W  = $clog2(MAX_BUS_BYTES) + 1,
    localparam int DW    = 8 * MAX_BUS_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CW_W-1:0]   cfg_bus_bytes,
    input  logic [CW_W-1:0]   cfg_chip_bytes,
    input  logic              cfg_big_endian,
    input  logic              cfg_bus_swap,
    input  logic              cfg_x16_as_x8,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [7:0]        req_cmd,
    input  logic [SECT_W-1:0] req_sector,
    input  logic [ADDR_W-1:0] req_sect_off,
    input  logic [OFF_W-1:0]  req_offset,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_ack,
    input  logic [DW-1:0]     bus_rdata
);
    flm_state_e        st_q, st_n;
    flm_op_e           op_q;
    logic [7:0]        cmd_q;
    logic [ADDR_W-1:0] base_q, soff_q;
    logic [OFF_W-1:0]  off_q;
    logic [CW_W-1:0]   bw_q, cw_q;
    logic              be_q, x16_q, err_q;
    logic [1:0]        beat_q, last_beat;
    logic [31:0]       acc_q;

    logic              cfg_ok, op_ok, accept;
    logic [DW-1:0]     fill;
    logic [7:0]        pick, merged, rd_byte;
    logic [ADDR_W-1:0] addr;

    assign op_ok  = (req_op <= 3'd4);
    assign accept = (st_q == ST_IDLE) && req_valid;

    flm_cfg_check #(.MAX_BUS_BYTES(MAX_BUS_BYTES), .CW_W(CW_W)) u_chk (
        .bus_bytes(cfg_bus_bytes), .chip_bytes(cfg_chip_bytes), .cfg_ok(cfg_ok));

    flm_lane_fill #(.MAX_BUS_BYTES(MAX_BUS_BYTES), .CW_W(CW_W)) u_fill (
        .cmd(cmd_q), .bus_bytes(bw_q), .chip_bytes(cw_q), .big(be_q), .wdata(fill));

    flm_addr_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CW_W(CW_W)) u_addr (
        .base(base_q), .sect_off(soff_q), .offset(off_q), .beat(beat_q),
        .x16(x16_q), .bus_bytes(bw_q), .addr(addr));

    flm_read_merge #(.MAX_BUS_BYTES(MAX_BUS_BYTES), .CW_W(CW_W)) u_merge (
        .rdata(bus_rdata), .bus_bytes(bw_q), .chip_bytes(cw_q), .big(be_q),
        .pick(pick), .merged(merged));

    always_comb begin
        unique case (op_q)
            OP_Q16:  last_beat = 2'd1;
            OP_Q32:  last_beat = 2'd3;
            default: last_beat = 2'd0;
        endcase
    end

    assign rd_byte = (op_q == OP_STAT) ? merged : pick;

    // next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_n = (cfg_ok && op_ok) ? ST_ACCESS : ST_RESP;
            ST_ACCESS: if (bus_ack && beat_q == last_beat) st_n = ST_RESP;
            ST_RESP:   st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // request capture and beat accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_CMD; cmd_q <= '0; base_q <= '0; soff_q <= '0; off_q <= '0;
            bw_q <= '0; cw_q <= '0; be_q <= 1'b0; x16_q <= 1'b0; err_q <= 1'b0;
            beat_q <= '0; acc_q <= '0;
        end else if (accept) begin
            op_q   <= flm_op_e'(req_op);
            cmd_q  <= req_cmd;
            base_q <= cfg_base;
            soff_q <= (req_sector == '0) ? '0 : req_sect_off;
            off_q  <= req_offset;
            bw_q   <= cfg_bus_bytes;
            cw_q   <= cfg_chip_bytes;
            be_q   <= cfg_big_endian ^ cfg_bus_swap;
            x16_q  <= cfg_x16_as_x8;
            err_q  <= !(cfg_ok && op_ok);
            beat_q <= '0;
            acc_q  <= '0;
        end else if (st_q == ST_ACCESS && bus_ack) begin
            if (op_q != OP_CMD) acc_q[8*beat_q +: 8] <= rd_byte;
            beat_q <= beat_q + 2'd1;
        end
    end

    // outputs
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        bus_req   = (st_q == ST_ACCESS);
        bus_we    = (st_q == ST_ACCESS) && (op_q == OP_CMD);
        bus_addr  = addr;
        bus_wdata = bus_we ? fill : '0;
        rsp_valid = (st_q == ST_RESP);
        rsp_err   = err_q;
        rsp_data  = acc_q;
    end

    AST_BAD_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_ok) |=> (rsp_valid && rsp_err && !bus_req)); // R1
    AST_UPPER_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> ((bus_wdata >> (8 * bw_q)) == '0)); // R2
    AST_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata))); // R9
    AST_SINGLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R9
    AST_BAD_OP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op > 3'd4) |=> (rsp_valid && rsp_err && !bus_req)); // R10
endmodule

// File: tb/tb_flash_lane_mapper.sv
`timescale 1ns/1ps
module tb_flash_lane_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [2:0]  cfg_bus_bytes = 3'd4, cfg_chip_bytes = 3'd1;
    logic        cfg_big_endian = 1'b0, cfg_bus_swap = 1'b0, cfg_x16_as_x8 = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [2:0]  req_op = '0;
    logic [7:0]  req_cmd = '0, req_sector = '0;
    logic [31:0] req_sect_off = '0;
    logic [15:0] req_offset = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_data;
    logic        bus_req, bus_we, bus_ack = 1'b0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] log_addr [8];
    logic [31:0] log_wd   [8];
    logic        log_we   [8];
    int          log_n = 0;
    int          wait_cnt = 0;

    always #2 clk = ~clk;

    flash_lane_mapper dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_bus_bytes(cfg_bus_bytes),
        .cfg_chip_bytes(cfg_chip_bytes), .cfg_big_endian(cfg_big_endian),
        .cfg_bus_swap(cfg_bus_swap), .cfg_x16_as_x8(cfg_x16_as_x8),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_cmd(req_cmd),
        .req_sector(req_sector), .req_sect_off(req_sect_off), .req_offset(req_offset),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata));

    function automatic logic [31:0] f_mem(input logic [31:0] a);
        logic [31:0] d;
        for (int k = 0; k < 4; k++)
            d[8*k +: 8] = (a[7:0] * 8'd7 + 8'(k * 13) + 8'h5A) ^ a[15:8] ^ a[23:16];
        return d;
    endfunction

    function automatic bit f_cfg_ok(input int bw, input int cw);
        return bw inside {1, 2, 4} && cw inside {1, 2, 4} && cw <= bw;
    endfunction

    function automatic logic [31:0] f_fill(input logic [7:0] cmd, input int bw, input int cw, input bit be);
        logic [31:0] w = '0;
        int p = 0;
        if (be) begin
            for (int i = 1; i <= bw; i++) begin
                if ((i & (cw - 1)) == 0) w[8*p +: 8] = cmd;
                p++;
            end
        end else begin
            for (int i = bw; i >= 1; i--) begin
                if ((i & (cw - 1)) == 0) w[8*p +: 8] = cmd;
                p++;
            end
        end
        return w;
    endfunction

    function automatic logic [31:0] f_addr(input logic [31:0] base, input logic [7:0] sec,
                                           input logic [31:0] so, input logic [15:0] off,
                                           input int i, input bit x16, input int bw);
        logic [31:0] o = x16 ? (32'(off) + 32'(i)) * 2 : 32'(off) + 32'(i);
        return base + ((sec != 0) ? so : 32'd0) + o * 32'(bw);
    endfunction

    function automatic logic [7:0] f_pick(input logic [31:0] d, input int bw, input bit be);
        return be ? d[8*(bw-1) +: 8] : d[7:0];
    endfunction

    function automatic logic [7:0] f_merge(input logic [31:0] d, input int bw, input int cw, input bit be);
        logic [7:0] r = '0;
        int n = bw / cw;
        for (int j = 0; j < n; j++) r |= be ? d[8*(bw-1-j) +: 8] : d[8*j +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bus responder with random acknowledge delay
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_req) begin
                if (wait_cnt == 0) begin
                    bus_ack = 1'b1;
                    bus_rdata = f_mem(bus_addr);
                    if (log_n < 8) begin
                        log_addr[log_n] = bus_addr;
                        log_wd[log_n] = bus_wdata;
                        log_we[log_n] = bus_we;
                    end
                    log_n++;
                    wait_cnt = $urandom % 3;
                end else wait_cnt--;
            end
        end
    end

    task automatic run_txn(input logic [2:0] op, input logic [7:0] cmd, input logic [7:0] sec,
                           input logic [31:0] so, input logic [15:0] off, input bit scramble);
        int bw = int'(cfg_bus_bytes), cw = int'(cfg_chip_bytes);
        bit be = cfg_big_endian ^ cfg_bus_swap, x16 = cfg_x16_as_x8;
        logic [31:0] base = cfg_base, exp_d;
        int beats, guard = 0;
        bit ok;
        string sfx = scramble ? " R12" : "";
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_cmd = cmd; req_sector = sec;
        req_sect_off = so; req_offset = off; log_n = 0;
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin
            cfg_bus_bytes = 3'($urandom); cfg_chip_bytes = 3'($urandom);
            cfg_big_endian = 1'($urandom); cfg_bus_swap = 1'($urandom);
            cfg_x16_as_x8 = 1'($urandom); cfg_base = $urandom;
        end
        while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
        if (guard >= 200) begin
            total++; bad++;
            $display("FAIL R9 actual=no response expected=response");
            return;
        end
        ok = f_cfg_ok(bw, cw);
        if (!ok || op > 3'd4) begin
            chk($sformatf("%s err%s", ok ? "R10" : "R1", sfx), 32'(rsp_err), 32'd1);
            chk($sformatf("%s no access%s", ok ? "R10" : "R1", sfx), 32'(log_n), 32'd0);
            return;
        end
        beats = (op == 3'd3) ? 2 : (op == 3'd4) ? 4 : 1;
        chk($sformatf("R9 access count%s", sfx), 32'(log_n), 32'(beats));
        chk($sformatf("R9 no err%s", sfx), 32'(rsp_err), 32'd0);
        if (log_n != beats) return;
        exp_d = '0;
        for (int i = 0; i < beats; i++) begin
            logic [31:0] a = f_addr(base, sec, so, off, i, x16, bw);
            chk($sformatf("%s addr beat %0d%s", x16 ? "R5" : "R4", i, sfx), log_addr[i], a);
            chk($sformatf("R2 write flag%s", sfx), 32'(log_we[i]), (op == 3'd0) ? 32'd1 : 32'd0);
            if (op == 3'd0)
                chk($sformatf("R2/R3 lanes bw=%0d cw=%0d be=%0d%s", bw, cw, be, sfx),
                    log_wd[i], f_fill(cmd, bw, cw, be));
            else if (op == 3'd2)
                exp_d[7:0] = f_merge(f_mem(a), bw, cw, be);
            else
                exp_d[8*i +: 8] = f_pick(f_mem(a), bw, be);
        end
        chk($sformatf("%s data%s", (op == 3'd0) ? "R2" : (op == 3'd1) ? "R6" :
                      (op == 3'd2) ? "R7" : "R8", sfx), rsp_data, exp_d);
    endtask

    task automatic set_cfg(input int bw, input int cw, input bit be, input bit sw, input bit x16);
        cfg_bus_bytes = 3'(bw); cfg_chip_bytes = 3'(cw);
        cfg_big_endian = be; cfg_bus_swap = sw; cfg_x16_as_x8 = x16;
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 req_ready", 32'(req_ready), 32'd1);
        chk("R11 bus_req", 32'(bus_req), 32'd0);
        chk("R11 rsp_valid", 32'(rsp_valid), 32'd0);

        cfg_base = 32'h1000_0000;
        set_cfg(3, 1, 0, 0, 0); run_txn(3'd1, 8'h00, 8'd0, 32'h0, 16'h10, 0);   // R1 non-power width
        set_cfg(2, 4, 0, 0, 0); run_txn(3'd0, 8'hAA, 8'd0, 32'h0, 16'h555, 0);  // R1 chip wider
        set_cfg(4, 0, 0, 0, 0); run_txn(3'd2, 8'h00, 8'd0, 32'h0, 16'h0, 0);    // R1 zero chip
        set_cfg(4, 2, 0, 0, 0); run_txn(3'd6, 8'h00, 8'd0, 32'h0, 16'h0, 0);    // R10
        run_txn(3'd0, 8'hAA, 8'd0, 32'h200, 16'h555, 0);  // R2 LE, sector 0 ignores offset (R4)
        set_cfg(4, 2, 1, 0, 0); run_txn(3'd0, 8'h55, 8'd3, 32'h2000, 16'h2AA, 0); // R3 BE
        set_cfg(4, 2, 1, 1, 0); run_txn(3'd0, 8'h90, 8'd1, 32'h400, 16'h0, 0);    // R3 swap
        set_cfg(4, 1, 0, 0, 0); run_txn(3'd2, 8'h00, 8'd0, 32'h0, 16'h0, 0);      // R7 four lanes
        set_cfg(4, 4, 1, 0, 0); run_txn(3'd2, 8'h00, 8'd0, 32'h0, 16'h3, 0);      // R7 one lane
        set_cfg(2, 1, 1, 0, 0); run_txn(3'd1, 8'h00, 8'd2, 32'h100, 16'h20, 0);   // R6
        set_cfg(2, 2, 0, 0, 1); run_txn(3'd3, 8'h00, 8'd0, 32'h0, 16'h13, 0);     // R5 R8
        set_cfg(4, 2, 0, 0, 0); run_txn(3'd4, 8'h00, 8'd5, 32'h8000, 16'h10, 1);  // R8 R12

        for (int t = 0; t < 300; t++) begin
            int bws [3] = '{1, 2, 4};
            int bw = bws[$urandom % 3], cw = bws[$urandom % 3];
            logic [2:0] op = ($urandom % 20 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
            if ($urandom % 25 == 0) bw = 3;
            cfg_base = $urandom & 32'hFFFF_FF00;
            set_cfg(bw, cw, 1'($urandom), 1'($urandom), 1'($urandom));
            run_txn(op, 8'($urandom), ($urandom % 3 == 0) ? 8'd0 : 8'($urandom),
                    $urandom & 32'h000F_FF00, 16'($urandom), 1'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule